// File: doc/BRIEF.md
# Rotate-Word-and-Mask Unit

This execution unit handles the 32-bit rotate-and-mask family of a 64-bit processor. Each operation takes the low word of a source operand and rotates it left. The rotate count is either a 5-bit immediate or the low five bits of a second register. The rotated value is then ANDed with a mask built from a begin field and an end field. In the insert form, the masked rotated bits are merged into the old destination value.

The two mask fields are offset by 32, so they index the low half of a 64-bit word. Bits are numbered big-endian, with bit 0 as the MSB. When begin is greater than end, the mask wraps around and covers the whole upper half of the result. To serve that case, the rotated word appears in both 32-bit halves of the rotator output.

When a record bit is set, the unit also produces a 4-bit condition field from the final result. Operands arrive on a valid/ready input stream. Results leave on a valid/ready output stream, through one optional register stage (`REG_OUT`, default 1).

Back-pressure rules for the registered stage:
- The stage accepts a new operand set whenever it is empty, or whenever its current result is taken in the same cycle.
- A result that is not taken stays on the outputs unchanged.

Top module: `rwm_unit`

## Requirements
- R1: Bits are numbered big-endian, with bit 0 as the MSB of the 64-bit word. The mask has ones at big-endian positions b=mb+32 through e=me+32 when mb<=me. When mb>me, the ones run from b through 63 and from 0 through e. So mb==me yields a single set bit.
- R2: Operation code 0 (rotate by immediate, AND) gives the result ({w,w} rotated left by sh_imm) AND mask, where w = src[31:0]. With sh_imm=0 this is {w,w} AND mask.
- R3: When mb<=me, result[63:32] is zero for the AND forms. When mb>me, result[63:32] equals the rotated word.
- R4: Operation code 1 (rotate by register, AND) uses only amt[4:0] as the rotate count. Bits amt[63:5] have no effect on the result.
- R5: Operation code 2 (insert) gives (rotated AND mask) OR (old_dst AND NOT mask), with the count taken from sh_imm.
- R6: Operation code 3 behaves exactly as code 0.
- R7: cr_field is {lt, gt, eq, so} from bit 3 down to bit 0. lt, gt and eq come from a signed 64-bit comparison of the result with zero, and so copies so_in of the same transfer.
- R8: cr_en equals the rec input of the transfer that produced the result.
- R9: With REG_OUT=1, a transfer accepted at one clock edge shows as out_valid with its result after that edge. in_ready is high exactly when the stage is empty or out_ready is high. While out_valid is high and out_ready is low, the outputs hold steady.
- R10: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set is presented |
| in_ready | output | 1 | Unit can take the operand set |
| op | input | 2 | 0 imm-AND, 1 reg-AND, 2 insert, 3 as 0 |
| src | input | 64 | Source operand; low word is rotated |
| amt | input | 64 | Rotate-count register (low 5 bits used) |
| old_dst | input | 64 | Prior destination value for insert |
| sh_imm | input | 5 | Immediate rotate count |
| mb | input | 5 | Mask begin field |
| me | input | 5 | Mask end field |
| rec | input | 1 | Request condition field update |
| so_in | input | 1 | Summary-overflow bit to pass through |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Operation result |
| cr_field | output | 4 | {lt, gt, eq, so} |
| cr_en | output | 1 | Condition field update enable |

## Verification
Two kinds of fault show up at the ports on the very next transfer:
- A bad mask term or a wrong rotator stage corrupts specific result bits. The bench sweeps all 1024 begin/end pairs with an all-ones source, so every mask bit is seen directly.
- Losing the upper-half duplication shows as a zero upper word in wrapped cases.

A fault in the output register or the handshake shows as data changing while stalled, or as in_ready asserted while full. The bench watches both over a held stall of several cycles.

// File: rtl/rwm_pkg.sv
package rwm_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = XLEN / 2;
  localparam int SHW  = $clog2(WLEN);

  typedef enum logic [1:0] {
    OP_AND_IMM = 2'd0,
    OP_AND_REG = 2'd1,
    OP_INSERT  = 2'd2,
    OP_ALIAS   = 2'd3
  } rwm_op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } rwm_cr_t;
endpackage

// File: rtl/rwm_mask_gen.sv
module rwm_mask_gen #(
  parameter int XLEN = 64,
  localparam int WLEN = XLEN / 2,
  localparam int SHW = $clog2(WLEN),
  localparam int PW = $clog2(XLEN)
) (
  input  logic [SHW-1:0]  mb,
  input  logic [SHW-1:0]  me,
  output logic [XLEN-1:0] mask
);
  logic [PW-1:0] beg_pos, end_pos;
  logic          wraps;

  // offset by WLEN: set the top bit of the position
  assign beg_pos = {1'b1, mb};
  assign end_pos = {1'b1, me};
  assign wraps   = beg_pos > end_pos;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam logic [PW-1:0] KPOS = PW'(XLEN - 1 - i);
    logic ge_b, le_e;
    assign ge_b = KPOS >= beg_pos;
    assign le_e = KPOS <= end_pos;
    assign mask[i] = wraps ? (ge_b | le_e) : (ge_b & le_e);
  end
endmodule

// File: rtl/rwm_rotator.sv
module rwm_rotator #(
  parameter int WLEN = 32,
  localparam int SHW = $clog2(WLEN)
) (
  input  logic [WLEN-1:0]   word,
  input  logic [SHW-1:0]    count,
  output logic [2*WLEN-1:0] rot_dup
);
  logic [WLEN-1:0] stage [SHW+1];

  assign stage[0] = word;
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = count[s]
      ? {stage[s][WLEN-1-D:0], stage[s][WLEN-1:WLEN-D]}
      : stage[s];
  end

  // doubled-word rotate equals the word rotate copied to both halves
  assign rot_dup = {stage[SHW], stage[SHW]};
endmodule

// File: rtl/rwm_cond.sv
module rwm_cond
  import rwm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  input  logic            so_in,
  output rwm_cr_t         cr
);
  logic zero;
  assign zero  = (value == '0);
  assign cr.lt = value[XLEN-1];
  assign cr.gt = ~value[XLEN-1] & ~zero;
  assign cr.eq = zero;
  assign cr.so = so_in;
endmodule

// File: rtl/rwm_unit.sv
module rwm_unit
  import rwm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] amt,
  input  logic [XLEN-1:0] old_dst,
  input  logic [SHW-1:0]  sh_imm,
  input  logic [SHW-1:0]  mb,
  input  logic [SHW-1:0]  me,
  input  logic            rec,
  input  logic            so_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cr_field,
  output logic            cr_en
);
  rwm_op_e         op_e;
  logic [SHW-1:0]  count;
  logic [XLEN-1:0] rot_dup, mask, and_val, res_c;
  rwm_cr_t         cr_c;

  assign op_e  = rwm_op_e'(op);
  assign count = (op_e == OP_AND_REG) ? amt[SHW-1:0] : sh_imm;

  rwm_rotator #(.WLEN(WLEN)) rot_i (
    .word(src[WLEN-1:0]), .count(count), .rot_dup(rot_dup)
  );
  rwm_mask_gen #(.XLEN(XLEN)) mask_i (.mb(mb), .me(me), .mask(mask));

  assign and_val = rot_dup & mask;
  assign res_c   = (op_e == OP_INSERT) ? (and_val | (old_dst & ~mask)) : and_val;

  rwm_cond #(.XLEN(XLEN)) cond_i (.value(res_c), .so_in(so_in), .cr(cr_c));

  if (REG_OUT) begin : g_reg
    logic            full_q, cr_en_q;
    logic [XLEN-1:0] res_q;
    rwm_cr_t         cr_q;
    logic            take;

    assign in_ready = ~full_q | out_ready;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q  <= 1'b0;
        res_q   <= '0;
        cr_q    <= '0;
        cr_en_q <= 1'b0;
      end else begin
        if (take) begin
          full_q  <= 1'b1;
          res_q   <= res_c;
          cr_q    <= cr_c;
          cr_en_q <= rec;
        end else if (out_ready) begin
          full_q  <= 1'b0;
        end
      end
    end

    assign out_valid = full_q;
    assign result    = res_q;
    assign cr_field  = cr_q;
    assign cr_en     = cr_en_q;

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(result) && $stable(cr_field));
    // R9
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    // R3
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && op != 2'd2 && mb <= me |=> result[XLEN-1:WLEN] == '0);
    // R5
    insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && op == 2'd2 |=> ((result ^ $past(old_dst)) & ~$past(mask)) == '0);
    // R7
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(cr_field[3:1]) == 1);
    // R8
    cr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !rec |=> !cr_en);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign result    = res_c;
    assign cr_field  = cr_c;
    assign cr_en     = rec;
  end
endmodule

// File: tb/rwm_unit_tb_top.sv
`timescale 1ns/100ps
module rwm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [1:0]  op;
  logic [63:0] src, amt, old_dst, result;
  logic [4:0]  sh_imm, mb, me;
  logic        rec, so_in, cr_en;
  logic [3:0]  cr_field;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rwm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .src(src), .amt(amt), .old_dst(old_dst), .sh_imm(sh_imm),
    .mb(mb), .me(me), .rec(rec), .so_in(so_in), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .cr_field(cr_field), .cr_en(cr_en)
  );

  function automatic logic [63:0] ref_mask(int b5, int e5);
    logic [63:0] m = '0;
    int b = b5 + 32;
    int e = e5 + 32;
    for (int k = 0; k < 64; k++) begin
      if (b <= e) m[63-k] = (k >= b) && (k <= e);
      else        m[63-k] = (k >= b) || (k <= e);
    end
    return m;
  endfunction

  function automatic logic [63:0] ref_rot(logic [31:0] w, int n);
    logic [63:0] d = {w, w};
    if (n == 0) return d;
    return (d << n) | (d >> (64 - n));
  endfunction

  function automatic logic [63:0] ref_res(logic [1:0] o, logic [63:0] s, logic [63:0] a,
                                          logic [63:0] od, int sh, int b5, int e5);
    logic [63:0] m = ref_mask(b5, e5);
    int n = (o == 2'd1) ? int'(a[4:0]) : sh;
    logic [63:0] r = ref_rot(s[31:0], n) & m;
    if (o == 2'd2) r = r | (od & ~m);
    return r;
  endfunction

  function automatic logic [3:0] ref_cr(logic [63:0] r, logic so);
    return {$signed(r) < 0, $signed(r) > 0, r == 0, so};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(string req, logic [1:0] o, logic [63:0] s, logic [63:0] a,
                      logic [63:0] od, logic [4:0] sh, logic [4:0] b5, logic [4:0] e5,
                      logic rc, logic so);
    logic [63:0] exp;
    @(negedge clk);
    op = o; src = s; amt = a; old_dst = od; sh_imm = sh; mb = b5; me = e5;
    rec = rc; so_in = so; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = ref_res(o, s, a, od, int'(sh), int'(b5), int'(e5));
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " result"}, result, exp);
    chk("R7 cr", 64'(cr_field), 64'(ref_cr(exp, so)));
    chk("R8 cr_en", 64'(cr_en), 64'(rc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    op = '0; src = '0; amt = '0; old_dst = '0; sh_imm = '0; mb = '0; me = '0;
    rec = 1'b0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", 64'(out_valid), 64'd0);

    // R1 R3: every begin/end pair, all-ones source shows the mask directly
    for (int b = 0; b < 32; b++)
      for (int e = 0; e < 32; e++)
        xfer("R1 mask", 2'd0, '1, '0, '0, 5'd0, 5'(b), 5'(e), 1'b1, 1'b0);

    // R3 directed wrap: upper half carries rotated word
    xfer("R3 wrap", 2'd0, 64'h0000_0000_8000_0001, '0, '0, 5'd4, 5'd1, 5'd0, 1'b0, 1'b0);
    chk("R3 upper", 64'(result[63:32]), 64'h0000_0000_0000_0018);
    // R4: upper bits of amt ignored, count 3 used
    xfer("R4 amt low bits", 2'd1, 64'h1, 64'hFFFF_FFFF_FFFF_FFE3, '0, 5'd9, 5'd0, 5'd31, 1'b0, 1'b0);
    chk("R4 value", result, 64'h8);
    // R5: insert single bit and wrapped insert
    xfer("R5 insert", 2'd2, 64'h0, '0, '1, 5'd0, 5'd7, 5'd7, 1'b1, 1'b1);
    xfer("R5 insert wrap", 2'd2, 64'h1234_5678_9ABC_DEF0, '0, 64'h5555_5555_5555_5555,
         5'd13, 5'd20, 5'd3, 1'b1, 1'b0);
    // R6: code 3 equals code 0
    xfer("R6 alias", 2'd3, 64'hDEAD_BEEF_0F0F_F0F0, 64'h7, '0, 5'd11, 5'd30, 5'd2, 1'b0, 1'b0);
    // R7: zero, positive, negative with so passed through
    xfer("R7 zero", 2'd0, 64'h0, '0, '0, 5'd0, 5'd0, 5'd31, 1'b1, 1'b1);
    xfer("R7 pos", 2'd0, '1, '0, '0, 5'd0, 5'd0, 5'd31, 1'b1, 1'b1);
    xfer("R7 neg", 2'd0, '1, '0, '0, 5'd0, 5'd1, 5'd0, 1'b1, 1'b0);
    // R2 R4 R5: random mix
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] o = 2'($urandom_range(3));
      xfer("R2 random", o, {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, 5'($urandom), 5'($urandom), 5'($urandom),
           1'($urandom), 1'($urandom));
    end

    // R9: stall holds data, in_ready drops while full
    @(negedge clk);
    out_ready = 1'b0;
    op = 2'd0; src = 64'hCAFE_F00D; sh_imm = 5'd5; mb = 5'd2; me = 5'd1;
    rec = 1'b1; so_in = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    held = ref_res(2'd0, 64'hCAFE_F00D, '0, '0, 5, 2, 1);
    for (int c = 0; c < 3; c++) begin
      chk("R9 stall valid", 64'(out_valid), 64'd1);
      chk("R9 stall data", result, held);
      chk("R9 stall ready", 64'(in_ready), 64'd0);
      src = {$urandom, $urandom};
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);
    chk("R9 ready", 64'(in_ready), 64'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule